// File: doc/BRIEF.md
# MSI Interrupt Request Controller

This block sits between application logic that wants to interrupt the host and the path that carries memory-write requests upstream. It keeps a small set of message-signalled interrupt settings: a global enable, a vector-count field, a 64-bit message address, a 16-bit message data word, and a mask bit and a pending bit for each vector. It also keeps the legacy-interrupt disable flag and drives it out to the legacy path. A simple configuration-write port loads these settings.

The application raises a request with a vector number and holds it until the block acknowledges it. The acknowledge lasts one cycle and carries a two-bit outcome. If the request is sent, the block presents one memory write on a valid/ready output, carrying the programmed address and the message data with the vector number merged into its low bits. If MSI is disabled, the request is dropped. If the vector is masked, the request is deferred. A deferred vector waits in its pending bit. When its mask is cleared, the block replays it on its own. If several deferred vectors are unmasked together, the lowest-numbered vector goes first.

Top module: `msi_req_ctrl`

## Requirements
- R1: After reset, `app_ack` and `wr_valid` are low, `msi_pending` is zero, `legacy_irq_off` is low and MSI is disabled.
- R2: A configuration write at offset 0x004 loads bit 10 into `legacy_irq_off`. Offset 0x050 loads the MSI enable from bit 16 and the vector-count field from bits 22:20. Offsets 0x054 and 0x058 load the low and high address words. Offset 0x05C loads the message data from bits 15:0. Offset 0x060 loads the mask, one bit per vector. A write to any other offset changes nothing.
- R3: An accepted request with MSI enabled and the vector unmasked is acknowledged one cycle after acceptance with status 0. In that same cycle `wr_valid` rises, with `wr_addr` equal to the programmed address and `wr_data` equal to the message data zero-extended to 32 bits.
- R4: The vector-count field N gives 2^N vectors, and values above log2 of NUM_VEC are treated as that maximum. The low N bits of the emitted data are replaced by the low N bits of the vector number. Higher vector bits are ignored.
- R5: A request made while MSI is disabled is acknowledged with status 2. No write is emitted and the pending bits are left unchanged.
- R6: A request for a masked vector is acknowledged with status 1. No write is emitted and that vector's pending bit is set.
- R7: A vector whose pending bit is set and whose mask bit is clear is replayed as a write. Its pending bit clears at the same clock edge where that write is taken (`wr_valid` and `wr_ready` both high).
- R8: When several pending vectors are unmasked together, their writes go out in ascending vector order.
- R9: While `wr_valid` is high and `wr_ready` is low, the write stays valid with a stable address and data. No new request is acknowledged until the outstanding write has been taken.
- R10: Each request held high until acknowledged receives exactly one acknowledge, and that acknowledge lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_ofs | input | 8 | Byte offset of the configuration dword |
| cfg_wr_data | input | 32 | Configuration write data |
| app_req | input | 1 | Interrupt request, held until acknowledged |
| app_vec | input | VEC_W | Requested vector number |
| app_ack | output | 1 | One-cycle acknowledge of a request |
| app_status | output | 2 | Outcome: 0 sent, 1 deferred, 2 dropped |
| wr_valid | output | 1 | Memory-write request valid |
| wr_ready | input | 1 | Downstream takes the write |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data |
| msi_pending | output | NUM_VEC | Pending bit per vector |
| legacy_irq_off | output | 1 | Legacy interrupt disable flag |

## Verification
The assertions assume that the application keeps `app_req` high until it sees `app_ack` and lowers it right after, and that the downstream side drives `wr_ready` only as a plain accept signal. In the bench, a single task drives each request. That task drops `app_req` on the falling edge after the acknowledge is seen, so no request is ever held into a second acceptance. The downstream monitor is the only process that drives `wr_ready`. It follows three patterns: always ready, ready one cycle in three, and stalled.

// File: rtl/msi_req_pkg.sv
package msi_req_pkg;
  localparam logic [7:0] OFS_CMD = 8'h04;
  localparam logic [7:0] OFS_CTL = 8'h50;
  localparam logic [7:0] OFS_ADL = 8'h54;
  localparam logic [7:0] OFS_ADH = 8'h58;
  localparam logic [7:0] OFS_DAT = 8'h5C;
  localparam logic [7:0] OFS_MSK = 8'h60;

  localparam int LEGACY_BIT = 10;
  localparam int ENABLE_BIT = 16;
  localparam int COUNT_LSB  = 20;
  localparam int COUNT_W    = 3;

  typedef enum logic [1:0] {
    ST_SENT = 2'd0,
    ST_PEND = 2'd1,
    ST_DROP = 2'd2
  } msi_status_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_req_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int VEC_W   = $clog2(NUM_VEC),
  parameter int MDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_ofs,
  input  logic [31:0]        wr_data,
  output logic               legacy_off,
  output logic               msi_en,
  output logic [VEC_W-1:0]   vec_field_mask,
  output logic [63:0]        msg_addr,
  output logic [MDATA_W-1:0] msg_data,
  output logic [NUM_VEC-1:0] vec_mask
);
  logic               legacy_q, legacy_n;
  logic               en_q, en_n;
  logic [COUNT_W-1:0] cnt_q, cnt_n;
  logic [31:0]        adl_q, adl_n, adh_q, adh_n;
  logic [MDATA_W-1:0] dat_q, dat_n;
  logic [NUM_VEC-1:0] msk_q, msk_n;
  logic               ce_cmd, ce_ctl, ce_adl, ce_adh, ce_dat, ce_msk;
  logic [COUNT_W-1:0] cnt_eff;

  always_comb begin
    ce_cmd = wr_en && (wr_ofs == OFS_CMD);
    ce_ctl = wr_en && (wr_ofs == OFS_CTL);
    ce_adl = wr_en && (wr_ofs == OFS_ADL);
    ce_adh = wr_en && (wr_ofs == OFS_ADH);
    ce_dat = wr_en && (wr_ofs == OFS_DAT);
    ce_msk = wr_en && (wr_ofs == OFS_MSK);
  end

  always_comb begin
    legacy_n = ce_cmd ? wr_data[LEGACY_BIT] : legacy_q;
    en_n     = ce_ctl ? wr_data[ENABLE_BIT] : en_q;
    cnt_n    = ce_ctl ? wr_data[COUNT_LSB +: COUNT_W] : cnt_q;
    adl_n    = ce_adl ? wr_data : adl_q;
    adh_n    = ce_adh ? wr_data : adh_q;
    dat_n    = ce_dat ? wr_data[MDATA_W-1:0] : dat_q;
    msk_n    = ce_msk ? wr_data[NUM_VEC-1:0] : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_q <= 1'b0;
      en_q     <= 1'b0;
      cnt_q    <= '0;
      adl_q    <= '0;
      adh_q    <= '0;
      dat_q    <= '0;
      msk_q    <= '0;
    end else begin
      legacy_q <= legacy_n;
      en_q     <= en_n;
      cnt_q    <= cnt_n;
      adl_q    <= adl_n;
      adh_q    <= adh_n;
      dat_q    <= dat_n;
      msk_q    <= msk_n;
    end
  end

  // Field values beyond what NUM_VEC supports are clipped to the maximum.
  always_comb begin
    if (int'(cnt_q) > VEC_W) cnt_eff = COUNT_W'(VEC_W);
    else                     cnt_eff = cnt_q;
  end

  for (genvar i = 0; i < VEC_W; i++) begin : g_fmask
    assign vec_field_mask[i] = (i < int'(cnt_eff));
  end

  assign legacy_off = legacy_q;
  assign msi_en     = en_q;
  assign msg_addr   = {adh_q, adl_q};
  assign msg_data   = dat_q;
  assign vec_mask   = msk_q;
endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
  parameter int NUM_VEC = 32,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_bits,
  input  logic [NUM_VEC-1:0] clr_bits,
  input  logic [NUM_VEC-1:0] vec_mask,
  output logic [NUM_VEC-1:0] pending,
  output logic               rep_any,
  output logic [VEC_W-1:0]   rep_idx
);
  logic [NUM_VEC-1:0] pend_q, pend_n, eligible;

  always_comb pend_n = (pend_q | set_bits) & ~clr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  assign eligible = pend_q & ~vec_mask;
  assign rep_any  = |eligible;

  // Lowest-numbered eligible vector wins.
  always_comb begin
    rep_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (eligible[i]) rep_idx = VEC_W'(i);
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/msi_wr_port.sv
module msi_wr_port #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              taken
);
  logic              vld_q, vld_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign taken = vld_q && ready;

  always_comb begin
    vld_n = vld_q;
    if (taken) vld_n = 1'b0;
    if (load)  vld_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  // Payload registers load only when a new write is launched.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= ld_addr;
      data_q <= ld_data;
    end
  end

  assign valid = vld_q;
  assign addr  = addr_q;
  assign data  = data_q;
endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
  import msi_req_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int MDATA_W = 16,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [7:0]         cfg_wr_ofs,
  input  logic [31:0]        cfg_wr_data,
  input  logic               app_req,
  input  logic [VEC_W-1:0]   app_vec,
  output logic               app_ack,
  output logic [1:0]         app_status,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [63:0]        wr_addr,
  output logic [31:0]        wr_data,
  output logic [NUM_VEC-1:0] msi_pending,
  output logic               legacy_irq_off
);
  logic               msi_en;
  logic [VEC_W-1:0]   fmask;
  logic [63:0]        msg_addr;
  logic [MDATA_W-1:0] msg_data;
  logic [NUM_VEC-1:0] vec_mask;
  logic [NUM_VEC-1:0] set_bits, clr_bits, pend;
  logic               rep_any;
  logic [VEC_W-1:0]   rep_idx;
  logic               accept, load_app, load_rep, load, taken;
  logic [VEC_W-1:0]   eff_vec, out_vec;
  logic [31:0]        ld_data;
  msi_status_e        code;
  logic               ack_q, ack_n;
  msi_status_e        st_q, st_n;
  logic               rinf_q, rinf_n;
  logic [VEC_W-1:0]   rvec_q, rvec_n;

  msi_cfg_regs #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .MDATA_W(MDATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_ofs(cfg_wr_ofs),
    .wr_data(cfg_wr_data), .legacy_off(legacy_irq_off), .msi_en(msi_en),
    .vec_field_mask(fmask), .msg_addr(msg_addr), .msg_data(msg_data),
    .vec_mask(vec_mask)
  );

  msi_pend_arb #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits),
    .vec_mask(vec_mask), .pending(pend), .rep_any(rep_any), .rep_idx(rep_idx)
  );

  msi_wr_port #(.ADDR_W(64), .DATA_W(32)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(msg_addr),
    .ld_data(ld_data), .ready(wr_ready), .valid(wr_valid), .addr(wr_addr),
    .data(wr_data), .taken(taken)
  );

  // Replays take precedence; new requests wait for an empty output slot.
  assign eff_vec = app_vec & fmask;
  assign accept  = app_req && !ack_q && !wr_valid && !rep_any;

  always_comb begin
    if (!msi_en)                code = ST_DROP;
    else if (vec_mask[eff_vec]) code = ST_PEND;
    else                        code = ST_SENT;
  end

  assign load_app = accept && (code == ST_SENT);
  assign load_rep = rep_any && !wr_valid;
  assign load     = load_app || load_rep;
  assign out_vec  = load_rep ? (rep_idx & fmask) : eff_vec;

  always_comb begin
    ld_data = 32'(msg_data);
    ld_data[VEC_W-1:0] = (msg_data[VEC_W-1:0] & ~fmask) | out_vec;
  end

  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    if (accept && (code == ST_PEND)) set_bits[eff_vec] = 1'b1;
    if (taken && rinf_q)             clr_bits[rvec_q]  = 1'b1;
  end

  always_comb begin
    ack_n  = accept;
    st_n   = accept ? code : st_q;
    rinf_n = rinf_q;
    rvec_n = rvec_q;
    if (taken)    rinf_n = 1'b0;
    if (load_rep) begin
      rinf_n = 1'b1;
      rvec_n = rep_idx;
    end else if (load_app) begin
      rinf_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      st_q   <= ST_SENT;
      rinf_q <= 1'b0;
      rvec_q <= '0;
    end else begin
      ack_q  <= ack_n;
      st_q   <= st_n;
      rinf_q <= rinf_n;
      rvec_q <= rvec_n;
    end
  end

  assign app_ack     = ack_q;
  assign app_status  = st_q;
  assign msi_pending = pend;
endmodule

// File: rtl/msi_req_ctrl_chk.sv
module msi_req_ctrl_chk #(
  parameter int NUM_VEC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               app_req,
  input logic               app_ack,
  input logic [1:0]         app_status,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [63:0]        wr_addr,
  input logic [31:0]        wr_data,
  input logic [NUM_VEC-1:0] msi_pending
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    app_ack |=> !app_ack); // R10
  AST_ACK_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    app_ack |-> $past(app_req) && !$past(wr_valid)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
  AST_SENT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (app_ack && app_status == 2'd0) |-> wr_valid); // R3
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (app_ack && app_status == 2'd2) |-> !wr_valid); // R5
  AST_DEFER_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (app_ack && app_status == 2'd1) |-> !wr_valid && (msi_pending != '0)); // R6
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    app_ack |-> app_status != 2'd3); // R3
endmodule

bind msi_req_ctrl msi_req_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .app_req(app_req), .app_ack(app_ack),
  .app_status(app_status), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .msi_pending(msi_pending)
);

// File: tb/test_msi_req_ctrl.sv
`timescale 1ns/1ps
module test_msi_req_ctrl;
  localparam int NV = 32;
  localparam int VW = 5;
  localparam logic [63:0] ADDR = 64'h0000_00F1_FEE0_1230;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [7:0]    cfg_wr_ofs = '0;
  logic [31:0]   cfg_wr_data = '0;
  logic          app_req = 1'b0;
  logic [VW-1:0] app_vec = '0;
  logic          app_ack;
  logic [1:0]    app_status;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [63:0]   wr_addr;
  logic [31:0]   wr_data;
  logic [NV-1:0] msi_pending;
  logic          legacy_irq_off;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [95:0] exp_q[$];

  always #2 clk = ~clk;

  msi_req_ctrl i_msi_req_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs),
    .cfg_wr_data(cfg_wr_data), .app_req(app_req), .app_vec(app_vec),
    .app_ack(app_ack), .app_status(app_status), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .msi_pending(msi_pending), .legacy_irq_off(legacy_irq_off)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: drives ready, pops the scoreboard on every taken write.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (ready_mode)
        0:       wr_ready = 1'b1;
        1:       wr_ready = (cyc % 3 == 0);
        default: wr_ready = 1'b0;
      endcase
      if (rst_n && wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected write", {wr_addr, wr_data}, '0);
        end else begin
          logic [95:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} === e, "R3/R4/R8 write payload", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic cfg_write(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_ofs = ofs;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic send_req(input logic [VW-1:0] v, input logic [1:0] exp_st,
                          input logic [15:0] exp_d, input string req);
    bit got;
    got = 1'b0;
    if (exp_st == 2'd0) exp_q.push_back({ADDR, 16'h0, exp_d});
    @(negedge clk);
    app_req = 1'b1;
    app_vec = v;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (app_ack) begin
        got = 1'b1;
        check(app_status == exp_st, req, 96'(app_status), 96'(exp_st));
        app_req = 1'b0;
        break;
      end
    end
    if (!got) check(1'b0, "R10 no acknowledge", 0, 1);
    @(negedge clk);
    check(!app_ack, "R10 acknowledge lasts one cycle", 96'(app_ack), 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R3 expected writes all seen", 96'(exp_q.size()), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!app_ack && !wr_valid, "R1 reset outputs", {94'(0), app_ack, wr_valid}, 0);
    check(msi_pending == '0 && !legacy_irq_off, "R1 reset state",
          96'(msi_pending), 0);
    rst_n = 1'b1;

    // Disabled: dropped, nothing pending, no write.
    send_req(5'd3, 2'd2, 16'h0, "R5 status when disabled");
    check(msi_pending == '0, "R5 pending untouched", 96'(msi_pending), 0);
    check(!wr_valid, "R5 no write", 96'(wr_valid), 0);

    // Configuration map.
    cfg_write(8'h04, 32'h0000_0400);
    check(legacy_irq_off, "R2 legacy disable set", 96'(legacy_irq_off), 1);
    cfg_write(8'h08, 32'h0000_0000);
    cfg_write(8'h70, 32'hFFFF_FFFF);
    check(legacy_irq_off, "R2 unused offsets ignored", 96'(legacy_irq_off), 1);
    cfg_write(8'h54, ADDR[31:0]);
    cfg_write(8'h58, ADDR[63:32]);
    cfg_write(8'h5C, 32'h0000_ABCD);
    cfg_write(8'h50, 32'h0001_0000);

    // One vector: data untouched by vector number.
    send_req(5'd0, 2'd0, 16'hABCD, "R3 sent status");
    send_req(5'd3, 2'd0, 16'hABCD, "R4 vector ignored with one vector");
    drain();

    // Eight vectors.
    cfg_write(8'h5C, 32'h0000_12F0);
    cfg_write(8'h50, 32'h0031_0000);
    send_req(5'd5, 2'd0, 16'h12F5, "R4 vector merged");
    send_req(5'd13, 2'd0, 16'h12F5, "R4 high vector bits ignored");
    drain();

    // Out-of-range field clipped to 32 vectors.
    cfg_write(8'h5C, 32'h0000_12FF);
    cfg_write(8'h50, 32'h0071_0000);
    send_req(5'd9, 2'd0, 16'h12E9, "R4 field clipped");
    drain();

    // Backpressure: write stalls, next request waits.
    cfg_write(8'h5C, 32'h0000_12F0);
    cfg_write(8'h50, 32'h0031_0000);
    ready_mode = 2;
    send_req(5'd1, 2'd0, 16'h12F1, "R9 first request sent");
    exp_q.push_back({ADDR, 16'h0, 16'h12F2});
    @(negedge clk);
    app_req = 1'b1;
    app_vec = 5'd2;
    begin
      bit early;
      early = 1'b0;
      repeat (6) begin
        @(negedge clk);
        if (app_ack) early = 1'b1;
      end
      check(!early && wr_valid, "R9 no ack while write outstanding",
            {94'(0), early, wr_valid}, 96'h1);
      check(wr_data == 32'h12F1, "R9 payload held", 96'(wr_data), 96'h12F1);
    end
    ready_mode = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (app_ack) begin
        check(app_status == 2'd0, "R9 second request after release", 96'(app_status), 0);
        app_req = 1'b0;
        break;
      end
    end
    app_req = 1'b0;
    drain();

    // Throttled ready, several requests.
    ready_mode = 1;
    for (int v = 0; v < 4; v++)
      send_req(VW'(v + 4), 2'd0, 16'h12F0 | 16'(v + 4), "R3 throttled stream");
    drain();
    ready_mode = 0;

    // Masking and replay.
    cfg_write(8'h60, 32'h0000_0024);
    send_req(5'd5, 2'd1, 16'h0, "R6 masked vector deferred");
    check(msi_pending == 32'h20, "R6 pending bit set", 96'(msi_pending), 96'h20);
    send_req(5'd2, 2'd1, 16'h0, "R6 second masked vector");
    check(msi_pending == 32'h24, "R6 pending bits", 96'(msi_pending), 96'h24);
    send_req(5'd1, 2'd0, 16'h12F1, "R6 unmasked vector still sent");
    drain();
    check(msi_pending == 32'h24, "R6 pending held while masked", 96'(msi_pending), 96'h24);

    exp_q.push_back({ADDR, 16'h0, 16'h12F2});
    exp_q.push_back({ADDR, 16'h0, 16'h12F5});
    cfg_write(8'h60, 32'h0000_0000);
    @(negedge clk);
    check(wr_valid && msi_pending == 32'h24, "R7 replay launched, bit still set",
          96'(msi_pending), 96'h24);
    @(negedge clk);
    check(msi_pending == 32'h20, "R8 lowest vector cleared first",
          96'(msi_pending), 96'h20);
    drain();
    check(msi_pending == '0, "R7 pending cleared after replay", 96'(msi_pending), 0);

    // Disable again.
    cfg_write(8'h50, 32'h0030_0000);
    send_req(5'd1, 2'd2, 16'h0, "R5 dropped after disable");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && !wr_valid, "R5 no write after drop", 96'(wr_valid), 0);

    finish_run();
  end
endmodule